// File: doc/BRIEF.md
# Line RDI Persistence Detector

The block watches one overhead byte (K2) of each received line frame and decides whether the far end is signalling a line remote defect. A frame carries the indication when the three least significant bits of K2 hold the code 3'b110. A single frame does not change the reported state. The defect is declared only after a programmable number of consecutive frames carry the indication. It is withdrawn only after the same number of consecutive frames without it.

A framer upstream presents the byte already aligned, together with a one-cycle frame strobe and an out-of-frame flag. While the framer is out of frame, the persistence count is held at zero. Every change of the reported state sets a sticky change flag. Software clears this flag through a clear input. The flag, gated by a mask bit, drives an interrupt line.

Top module: `line_rdi_det`

## Requirements
- R1: A frame carries the indication exactly when K2[2:0] == 3'b110. Bits K2[7:3] have no effect on the result.
- R2: With the reported state clear, it becomes set on the clock edge that samples the N-th consecutive strobed frame carrying the indication. N is the 4-bit persistence setting.
- R3: With the reported state set, it becomes clear on the clock edge that samples the N-th consecutive strobed frame without the indication.
- R4: A strobed frame that agrees with the current reported state restarts the consecutive count at zero and leaves the state unchanged.
- R5: A persistence setting of 0 behaves as 1, so a single disagreeing frame changes the state.
- R6: In any cycle with the out-of-frame input high, the count is forced to zero, the frame strobe is ignored and the state holds.
- R7: Each change of the reported state, in either direction, sets the change flag on the same edge. The flag then stays set.
- R8: The clear input resets the change flag on the next edge. A state change on that same edge wins, and the flag stays set.
- R9: The interrupt output equals the change flag while the mask input is low, and is low while the mask input is high.
- R10: After reset the state is clear, the change flag is clear and the count is zero.
- R11: Cycles without a frame strobe leave the count and the state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe: k2_i holds this frame's byte |
| k2_i | input | 8 | Received K2 overhead byte |
| oof_i | input | 1 | Framer out-of-frame indication |
| persist_i | input | 4 | Consecutive-frame count for declare and clear (0 acts as 1) |
| mask_i | input | 1 | Interrupt mask, 1 suppresses irq_o |
| delta_clr_i | input | 1 | Clears the change flag |
| rdi_o | output | 1 | Current line remote defect state |
| delta_o | output | 1 | Sticky state-change flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions assume three things about the inputs: the frame strobe is a single-cycle pulse, the out-of-frame flag is a level sampled on every clock, and the persistence setting changes only between frames. The stimulus holds all inputs steady across each rising edge and drives them at the falling edge. It moves the persistence setting only between runs, except in a randomized phase where a change lands between strobes. Run lengths are swept from one frame to one past the setting for every setting value. Out-of-frame pulses, masks, clears and idle cycles are interleaved so that count restarts and clear-versus-change collisions both occur.

// File: rtl/rdi_pkg.sv
`timescale 1ns/1ps
package rdi_pkg;
  localparam int unsigned K2_W   = 8;
  localparam int unsigned CODE_W = 3;
  localparam logic [CODE_W-1:0] RDI_CODE = 3'b110;
endpackage

// File: rtl/rdi_match.sv
`timescale 1ns/1ps
module rdi_match
  import rdi_pkg::*;
(
  input  logic            frame_i,
  input  logic            oof_i,
  input  logic [K2_W-1:0] k2_i,
  output logic            strobe_o,
  output logic            ind_o
);
  // frames seen while out of frame do not count
  assign strobe_o = frame_i & ~oof_i;
  assign ind_o    = (k2_i[CODE_W-1:0] == RDI_CODE);
endmodule

// File: rtl/rdi_persist.sv
`timescale 1ns/1ps
module rdi_persist #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oof_i,
  input  logic             strobe_i,
  input  logic             ind_i,
  input  logic [CNT_W-1:0] persist_i,
  output logic             state_o,
  output logic             chg_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             state_q, state_d;
  logic [EXT_W-1:0] limit, cnt_inc;
  logic             differ;

  assign limit   = (persist_i == '0) ? EXT_W'(1) : {1'b0, persist_i};
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign differ  = strobe_i & (ind_i != state_q);

  always_comb begin
    cnt_d   = cnt_q;
    state_d = state_q;
    chg_o   = 1'b0;
    if (oof_i) begin
      cnt_d = '0;
    end else if (strobe_i) begin
      if (!differ) begin
        cnt_d = '0;
      end else if (cnt_inc >= limit) begin
        cnt_d   = '0;
        state_d = ind_i;
        chg_o   = 1'b1;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  assert_oof_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oof_i |=> (cnt_q == '0) && $stable(state_q));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !oof_i) |=> $stable(state_q) && $stable(cnt_q));
  assert_run_break_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (ind_i == state_q)) |=> (cnt_q == '0) && $stable(state_q));
  assert_min_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && (ind_i != state_q) && (persist_i <= CNT_W'(1))) |=> (state_q == $past(ind_i)));
endmodule

// File: rtl/rdi_event.sv
`timescale 1ns/1ps
module rdi_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic delta_o,
  output logic irq_o
);
  logic delta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     delta_q <= 1'b0;
    else if (chg_i)  delta_q <= 1'b1; // change beats clear
    else if (clr_i)  delta_q <= 1'b0;
  end

  assign delta_o = delta_q;
  assign irq_o   = delta_q & ~mask_i;

  assert_delta_on_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> delta_o);
  assert_clr_effect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !chg_i) |=> !delta_o);
  assert_delta_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delta_o && !clr_i) |=> delta_o);
endmodule

// File: rtl/line_rdi_det.sv
`timescale 1ns/1ps
module line_rdi_det
  import rdi_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [K2_W-1:0]  k2_i,
  input  logic             oof_i,
  input  logic [CNT_W-1:0] persist_i,
  input  logic             mask_i,
  input  logic             delta_clr_i,
  output logic             rdi_o,
  output logic             delta_o,
  output logic             irq_o
);
  logic strobe, ind, chg;

  rdi_match u_match (
    .frame_i  (frame_i),
    .oof_i    (oof_i),
    .k2_i     (k2_i),
    .strobe_o (strobe),
    .ind_o    (ind)
  );

  rdi_persist #(.CNT_W(CNT_W)) u_persist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oof_i     (oof_i),
    .strobe_i  (strobe),
    .ind_i     (ind),
    .persist_i (persist_i),
    .state_o   (rdi_o),
    .chg_o     (chg)
  );

  rdi_event u_event (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .chg_i   (chg),
    .clr_i   (delta_clr_i),
    .mask_i  (mask_i),
    .delta_o (delta_o),
    .irq_o   (irq_o)
  );

  assert_change_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdi_o) |-> delta_o);
endmodule

// File: tb/line_rdi_det_tb_top.sv
`timescale 1ns/1ps
module line_rdi_det_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic [7:0] k2 = 8'h00;
  logic       oof = 1'b0;
  logic [3:0] persist = 4'd0;
  logic       mask = 1'b0;
  logic       clr = 1'b0;
  logic       rdi, delta, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  bit m_state = 0;
  bit m_delta = 0;
  int m_cnt = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  line_rdi_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .k2_i(k2), .oof_i(oof),
    .persist_i(persist), .mask_i(mask), .delta_clr_i(clr),
    .rdi_o(rdi), .delta_o(delta), .irq_o(irq)
  );

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // byte with or without the 3'b110 code, upper bits random
  function automatic logic [7:0] mk_k2(input bit ind);
    logic [31:0] r;
    logic [2:0]  lo;
    r  = rnd();
    lo = r[2:0];
    if (!ind && lo == 3'b110) lo = 3'b111;
    return {r[15:11], ind ? 3'b110 : lo};
  endfunction

  task automatic step(input bit f, input logic [7:0] k, input bit o, input bit c);
    int  lim;
    bit  ind, chg;
    @(negedge clk);
    frame = f; k2 = k; oof = o; clr = c;
    @(posedge clk);
    lim = (persist == 0) ? 1 : int'(persist);
    ind = (k[2:0] == 3'b110);
    chg = 0;
    if (o) m_cnt = 0;
    else if (f) begin
      if (ind == m_state) m_cnt = 0;
      else if (m_cnt + 1 >= lim) begin m_cnt = 0; m_state = ind; chg = 1; end
      else m_cnt++;
    end
    if (chg) m_delta = 1;
    else if (c) m_delta = 0;
    #1;
    chk(rdi == m_state, "R1 R2 R3 R4 R5 R6 R11 state", rdi, m_state);
    chk(delta == m_delta, "R7 R8 delta", delta, m_delta);
    chk(irq == (m_delta & ~mask), "R9 irq", irq, m_delta & ~mask);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rdi == 0, "R10 state", rdi, 0);
    chk(delta == 0, "R10 delta", delta, 0);
    chk(irq == 0, "R10 irq", irq, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: setting 0, one frame sets, one clears
    persist = 4'd0;
    step(1, 8'h06, 0, 0);
    chk(rdi == 1, "R5 set by one frame", rdi, 1);
    step(1, 8'h07, 0, 1);
    chk(rdi == 0, "R5 clear by one frame", rdi, 0);
    // R8: clear wins only without a change
    step(0, 8'h00, 0, 1);
    chk(delta == 0, "R8 clear", delta, 0);
    step(1, 8'hFE, 0, 1);
    chk(delta == 1, "R8 change beats clear", delta, 1);
    // R1: upper bits ignored, code FE ends in 110
    chk(rdi == 1, "R1 upper bits ignored", rdi, 1);
    step(1, 8'h06, 0, 1);

    // R6: run broken by out of frame
    persist = 4'd3;
    step(1, 8'h00, 0, 0);
    step(1, 8'h00, 0, 0);
    step(1, 8'h00, 1, 0);
    step(1, 8'h00, 0, 0);
    step(1, 8'h00, 0, 0);
    chk(rdi == 1, "R6 count restarted by oof", rdi, 1);
    step(1, 8'h00, 0, 0);
    chk(rdi == 0, "R3 cleared after three", rdi, 0);
    // R4: run broken by agreeing frame, R11 idle gap
    step(1, 8'h06, 0, 1);
    step(0, 8'h06, 0, 0);
    step(1, 8'h06, 0, 0);
    step(1, 8'h05, 0, 0);
    step(1, 8'h06, 0, 0);
    step(1, 8'h06, 0, 0);
    chk(rdi == 0, "R4 run restarted", rdi, 0);
    step(1, 8'h06, 0, 0);
    chk(rdi == 1, "R2 set after three with gap", rdi, 1);
    // R9 mask
    mask = 1;
    step(0, 8'h00, 0, 0);
    chk(irq == 0, "R9 masked", irq, 0);
    mask = 0;
    step(0, 8'h00, 0, 0);
    chk(irq == 1, "R9 unmasked", irq, 1);

    // sweep every setting and run lengths around it
    for (int cfg = 0; cfg < 16; cfg++) begin
      persist = 4'(cfg);
      for (int len = 1; len <= 17; len++) begin
        for (int ph = 0; ph < 2; ph++) begin
          for (int i = 0; i < len; i++) begin
            logic [31:0] r;
            r = rnd();
            mask = r[20];
            if (r[21] && r[22]) step(0, 8'h00, 0, 0);
            step(1, mk_k2(ph == 0), 0, r[23] && r[24]);
          end
          // one breaking frame between phases
          step(1, mk_k2(ph != 0), 0, 1);
        end
      end
    end

    // randomized mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = rnd();
      mask = r[8];
      if (r[27:24] == 0) persist = r[3:0];
      step(r[9] | r[10], mk_k2(r[11] | r[12]), r[15:13] == 0, r[18:16] == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule